// File: doc/BRIEF.md
# Data-Processing Operand Barrel Shifter

This block produces the second operand and the shifter carry-out for the register-operand forms of data-processing instructions in a 32-bit core. It decodes the shift kind and the shift source from the instruction word. It takes the Rm and Rs register values that the register file has already read, and it applies the shift together with the architectural special cases. These are the re-encoded zero-amount immediate shifts, the rules for register amounts of 32 and above, and the program-counter read offset in register form. It also raises a flag when the instruction needs one extra internal cycle.

The shifter is combinational. An optional output register (parameter `REG_OUT`, on by default) places the result one clock after the inputs, so the block can sit at the end of an operand-fetch stage. The rotated-immediate operand form, the ALU, flag writeback and register-file access all sit outside this block.

Top module: `opnd_shifter`

## Requirements
- R1: Instruction bit 4 selects the form: 0 gives an immediate amount taken from bits 11:7, 1 gives a register amount taken from `rs_val`. Bits 6:5 give the shift kind (00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right). Bits 3:0 name Rm and bits 11:8 name Rs, and these fields are used only to detect register 15.
- R2: An immediate amount of 1 to 31 performs the plain shift or rotate of `rm_val`. The carry-out is the last bit shifted out.
- R3: An immediate left logical shift by 0 passes `rm_val` through unchanged and outputs `carry_in` as the carry.
- R4: An immediate right logical shift by 0 acts as a shift by 32: result 0, carry = bit 31. An immediate right arithmetic shift by 0 fills the result with bit 31, and the carry equals bit 31.
- R5: An immediate rotate by 0 performs a 33-bit rotate through carry. The result is {carry_in, rm_val[31:1]} and the carry is rm_val[0].
- R6: In register form only bits 7:0 of the (adjusted) Rs value set the amount. An amount of 0 passes Rm through with carry = `carry_in`, for every kind.
- R7: Register-form left and right logical shifts by 1 to 31 behave as plain shifts, with the carry taken from the last bit shifted out. An amount of exactly 32 gives 0 with carry = bit 0 (left) or bit 31 (right). Amounts above 32 give 0 with carry 0.
- R8: Register-form right arithmetic shifts by 32 or more give all ones with carry 1 for a negative operand, and 0 with carry 0 otherwise.
- R9: A register-form rotate uses amount bits 4:0. When the amount is nonzero but those five bits are zero, the operand is unchanged and the carry equals bit 31.
- R10: In register form, a field equal to 15 adds 4 to the value used for that register, for Rm and Rs independently. In immediate form no adjustment is made.
- R11: `extra_cycle` is 1 for register form and 0 for immediate form.
- R12: With `REG_OUT`=1, outputs show the result for the inputs present at the previous rising clock edge. A synchronous active-low reset clears all three outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| insn | input | 32 | Instruction word |
| rm_val | input | 32 | Value read for the register named in bits 3:0 |
| rs_val | input | 32 | Value read for the register named in bits 11:8 |
| carry_in | input | 1 | Current carry flag |
| opnd_out | output | 32 | Shifted second operand |
| carry_out | output | 1 | Shifter carry-out |
| extra_cycle | output | 1 | Request for one extra internal cycle |

## Verification
The bench compares every result against a bit-serial reference model. It sweeps each shift kind in register form over amounts 0, 1, 31, 32, 33, 64, 255 and a value whose upper bits must be ignored, and in immediate form over 0, 1, 15 and 31. A shifter that treats the immediate zero amount literally would return Rm instead of zero, sign fill or the rotate through carry. One that clamps or wraps register amounts wrongly would produce nonzero results or the wrong carry at 32 and 33. One that misses the rotate-by-multiple-of-32 rule would report the old carry instead of bit 31. Register-15 cases with Rs reading 28 or 0xFFFFFFFC show whether the offset of 4 is applied, because the amount becomes exactly 32 or wraps to 0. The immediate-form register-15 case shows that the offset is not applied outside register form.

// File: rtl/shf_pkg.sv
// Shared types for the operand barrel shifter.
// Assumes: register-form amounts use an 8-bit field, and the kind encoding
// follows instruction bits 6:5.
package shf_pkg;

    localparam int AMT_W = 8;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_kind_e;

    // Normalised shift command handed from decode to the datapath
    typedef struct packed {
        shift_kind_e        kind;
        logic               rrx;
        logic [AMT_W-1:0]   amount;
    } shf_ctl_t;

endpackage

// File: rtl/shf_decode.sv
// Decodes the instruction word into a normalised shift command and applies
// the register-15 read offset.
// Immediate zero amounts are rewritten here: right logical or arithmetic #0
// become amount DATA_W, and rotate #0 becomes the rrx flag. The datapath
// therefore never sees those encodings.
// Assumes DATA_W fits in AMT_W bits and the instruction fields are fixed.
module shf_decode
    import shf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PC_IDX = 15,
    parameter int PC_ADJ = 4
) (
    input  logic [31:0]       insn,
    input  logic [DATA_W-1:0] rm_val,
    input  logic [DATA_W-1:0] rs_val,
    output shf_ctl_t          ctl,
    output logic [DATA_W-1:0] opnd,
    output logic              reg_form
);

    localparam int IMM_W = 5;

    logic [IMM_W-1:0] imm_amt;
    logic [3:0]       rm_idx;
    logic [3:0]       rs_idx;
    shift_kind_e      kind;
    logic [AMT_W-1:0] rs_amt;
    logic             unused_bits;

    assign reg_form = insn[4];
    assign imm_amt  = insn[11:7];
    assign rm_idx   = insn[3:0];
    assign rs_idx   = insn[11:8];
    assign kind     = shift_kind_e'(insn[6:5]);
    assign unused_bits = ^{insn[31:12], rs_val[DATA_W-1:AMT_W]};

    // Operand value: offset applied to register 15 in register form only
    always_comb begin
        opnd = rm_val;
        if (reg_form && rm_idx == 4'(PC_IDX))
            opnd = rm_val + DATA_W'(PC_ADJ);
    end

    // Register amount: low bits of Rs, with the register-15 offset folded in
    always_comb begin
        rs_amt = rs_val[AMT_W-1:0];
        if (rs_idx == 4'(PC_IDX))
            rs_amt = rs_val[AMT_W-1:0] + AMT_W'(PC_ADJ);
    end

    // Normalise both forms into one amount plus the rotate-through-carry flag
    always_comb begin
        ctl.kind   = kind;
        ctl.rrx    = 1'b0;
        ctl.amount = '0;
        if (reg_form) begin
            ctl.amount = rs_amt;
        end else if (imm_amt != '0) begin
            ctl.amount = AMT_W'(imm_amt);
        end else begin
            unique case (kind)
                SH_LSL: ctl.amount = '0;
                SH_LSR: ctl.amount = AMT_W'(DATA_W);
                SH_ASR: ctl.amount = AMT_W'(DATA_W);
                SH_ROR: ctl.rrx    = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/shf_core.sv
// Barrel shifter datapath: computes result and carry from a normalised command.
// Each logical and arithmetic shift runs on a DATA_W+1 wide vector, and the
// extra bit catches the last bit shifted out. Amounts of DATA_W and above
// therefore need no separate clamping.
// Assumes DATA_W is a power of two.
module shf_core
    import shf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opnd,
    input  shf_ctl_t          ctl,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              carry
);

    localparam int ROT_W = $clog2(DATA_W);

    logic [DATA_W:0]   lsl_ext;
    logic [DATA_W:0]   lsr_ext;
    logic [DATA_W:0]   asr_ext;
    logic [ROT_W-1:0]  rot_amt;
    logic [ROT_W:0]    rot_back;
    logic [DATA_W-1:0] rot_val;

    // Candidate results for every kind, computed in parallel
    always_comb begin
        lsl_ext  = {1'b0, opnd} << ctl.amount;
        lsr_ext  = {opnd, 1'b0} >> ctl.amount;
        asr_ext  = $unsigned($signed({opnd, 1'b0}) >>> ctl.amount);
        rot_amt  = ctl.amount[ROT_W-1:0];
        rot_back = (ROT_W+1)'(DATA_W) - {1'b0, rot_amt};
        rot_val  = (opnd >> rot_amt) | (opnd << rot_back);
    end

    // Select the candidate and its carry by kind and special case
    always_comb begin
        result = opnd;
        carry  = carry_in;
        if (ctl.rrx) begin
            result = {carry_in, opnd[DATA_W-1:1]};
            carry  = opnd[0];
        end else if (ctl.amount != '0) begin
            unique case (ctl.kind)
                SH_LSL: begin
                    result = lsl_ext[DATA_W-1:0];
                    carry  = lsl_ext[DATA_W];
                end
                SH_LSR: begin
                    result = lsr_ext[DATA_W:1];
                    carry  = lsr_ext[0];
                end
                SH_ASR: begin
                    result = asr_ext[DATA_W:1];
                    carry  = asr_ext[0];
                end
                SH_ROR: begin
                    result = rot_val;
                    carry  = rot_val[DATA_W-1];
                end
            endcase
        end
    end

endmodule

// File: rtl/shf_stage.sv
// Optional output register for the shifter results.
// REG_OUT=1 registers the outputs with a synchronous active-low clear.
// REG_OUT=0 passes the inputs straight through.
module shf_stage #(
    parameter int DATA_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] d_res,
    input  logic              d_carry,
    input  logic              d_extra,
    output logic [DATA_W-1:0] q_res,
    output logic              q_carry,
    output logic              q_extra
);

    generate
        if (REG_OUT) begin : g_reg
            // Capture the shifter outputs each cycle and clear them on reset
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q_res   <= '0;
                    q_carry <= 1'b0;
                    q_extra <= 1'b0;
                end else begin
                    q_res   <= d_res;
                    q_carry <= d_carry;
                    q_extra <= d_extra;
                end
            end
        end else begin : g_comb
            // Pass the outputs straight through
            always_comb begin
                q_res   = d_res;
                q_carry = d_carry;
                q_extra = d_extra;
            end
        end
    endgenerate

endmodule

// File: rtl/opnd_shifter.sv
// Top of the data-processing operand barrel shifter.
// Connects decode, datapath and the optional output stage.
// Assumes that register values for the Rm and Rs fields arrive on rm_val and
// rs_val during the same cycle as insn.
module opnd_shifter
    import shf_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter bit REG_OUT = 1'b1,
    parameter int PC_IDX  = 15,
    parameter int PC_ADJ  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       insn,
    input  logic [DATA_W-1:0] rm_val,
    input  logic [DATA_W-1:0] rs_val,
    input  logic              carry_in,
    output logic [DATA_W-1:0] opnd_out,
    output logic              carry_out,
    output logic              extra_cycle
);

    shf_ctl_t          ctl;
    logic [DATA_W-1:0] opnd;
    logic              reg_form;
    logic [DATA_W-1:0] sh_res;
    logic              sh_carry;

    shf_decode #(
        .DATA_W (DATA_W),
        .PC_IDX (PC_IDX),
        .PC_ADJ (PC_ADJ)
    ) u_decode (
        .insn     (insn),
        .rm_val   (rm_val),
        .rs_val   (rs_val),
        .ctl      (ctl),
        .opnd     (opnd),
        .reg_form (reg_form)
    );

    shf_core #(
        .DATA_W (DATA_W)
    ) u_core (
        .opnd     (opnd),
        .ctl      (ctl),
        .carry_in (carry_in),
        .result   (sh_res),
        .carry    (sh_carry)
    );

    shf_stage #(
        .DATA_W  (DATA_W),
        .REG_OUT (REG_OUT)
    ) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_res   (sh_res),
        .d_carry (sh_carry),
        .d_extra (reg_form),
        .q_res   (opnd_out),
        .q_carry (carry_out),
        .q_extra (extra_cycle)
    );

endmodule

// File: rtl/opnd_shifter_chk.sv
// Property checker for opnd_shifter, attached by bind.
// Keeps its own copy of the inputs so that it lines up with the output
// latency chosen by REG_OUT.
module opnd_shifter_chk #(
    parameter int DATA_W  = 32,
    parameter bit REG_OUT = 1'b1,
    parameter int PC_IDX  = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       insn,
    input logic [DATA_W-1:0] rm_val,
    input logic [DATA_W-1:0] rs_val,
    input logic              carry_in,
    input logic [DATA_W-1:0] opnd_out,
    input logic              carry_out,
    input logic              extra_cycle
);

    logic [31:0]       v_insn;
    logic [DATA_W-1:0] v_rm;
    logic [DATA_W-1:0] v_rs;
    logic              v_cin;
    logic              v_vld;
    logic              v_rm_pc;
    logic              v_rs_pc;
    logic              unused_chk;

    generate
        if (REG_OUT) begin : g_lat
            // Inputs as seen by the current registered outputs
            always_ff @(posedge clk) begin
                v_insn <= insn;
                v_rm   <= rm_val;
                v_rs   <= rs_val;
                v_cin  <= carry_in;
                v_vld  <= rst_n;
            end
        end else begin : g_now
            // Outputs follow the inputs directly
            always_comb begin
                v_insn = insn;
                v_rm   = rm_val;
                v_rs   = rs_val;
                v_cin  = carry_in;
                v_vld  = 1'b1;
            end
        end
    endgenerate

    assign v_rm_pc    = (v_insn[3:0] == 4'(PC_IDX));
    assign v_rs_pc    = (v_insn[11:8] == 4'(PC_IDX));
    assign unused_chk = ^{v_insn[31:12], v_rs[DATA_W-1:8]};

    // R11
    extra_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_vld |-> (extra_cycle == v_insn[4]));

    // R3
    imm_lsl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_vld && !v_insn[4] && v_insn[11:5] == 7'd0)
        |-> (opnd_out == v_rm && carry_out == v_cin));

    // R5
    imm_rrx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_vld && !v_insn[4] && v_insn[11:7] == 5'd0 && v_insn[6:5] == 2'b11)
        |-> (opnd_out == {v_cin, v_rm[DATA_W-1:1]} && carry_out == v_rm[0]));

    // R6
    reg_zero_amt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_vld && v_insn[4] && !v_rm_pc && !v_rs_pc && v_rs[7:0] == 8'd0)
        |-> (opnd_out == v_rm && carry_out == v_cin));

    // R7
    reg_logical_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_vld && v_insn[4] && !v_rs_pc && !v_insn[6] && v_rs[7:0] > 8'd32)
        |-> (opnd_out == '0 && !carry_out));

    // R8
    reg_asr_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_vld && v_insn[4] && !v_rs_pc && !v_rm_pc && v_insn[6:5] == 2'b10
         && v_rs[7:0] >= 8'd32)
        |-> (opnd_out == {DATA_W{v_rm[DATA_W-1]}} && carry_out == v_rm[DATA_W-1]));

    generate
        if (REG_OUT) begin : g_rst_chk
            // R12
            reset_clear_chk: assert property (@(posedge clk)
                !rst_n |=> (opnd_out == '0 && !carry_out && !extra_cycle));
        end
    endgenerate

endmodule

bind opnd_shifter opnd_shifter_chk #(
    .DATA_W  (DATA_W),
    .REG_OUT (REG_OUT),
    .PC_IDX  (PC_IDX)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .insn        (insn),
    .rm_val      (rm_val),
    .rs_val      (rs_val),
    .carry_in    (carry_in),
    .opnd_out    (opnd_out),
    .carry_out   (carry_out),
    .extra_cycle (extra_cycle)
);

// File: tb/sim_opnd_shifter.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes model results and the monitor compares
// them one clock later.
module sim_opnd_shifter;

    localparam int WD_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn = 32'hE1A0_1452;
    logic [31:0] rm_val = 32'hDEAD_BEEF;
    logic [31:0] rs_val = 32'h0000_0003;
    logic        carry_in = 1'b1;
    logic [31:0] opnd_out;
    logic        carry_out;
    logic        extra_cycle;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [33:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    opnd_shifter #(
        .DATA_W  (32),
        .REG_OUT (1'b1)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .insn        (insn),
        .rm_val      (rm_val),
        .rs_val      (rs_val),
        .carry_in    (carry_in),
        .opnd_out    (opnd_out),
        .carry_out   (carry_out),
        .extra_cycle (extra_cycle)
    );

    // Bit-serial reference model: returns {extra, carry, result}
    function automatic logic [33:0] ref_model(logic [31:0] ins, logic [31:0] rm,
                                              logic [31:0] rs, logic cin);
        logic [31:0] v;
        logic [31:0] a;
        logic        c;
        logic        b0;
        int          n;
        logic        regf;
        logic [1:0]  k;
        regf = ins[4];
        k    = ins[6:5];
        v    = rm;
        c    = cin;
        if (regf) begin
            if (ins[3:0] == 4'hF) v = rm + 32'd4;
            a = rs + ((ins[11:8] == 4'hF) ? 32'd4 : 32'd0);
            n = int'(a[7:0]);
        end else begin
            n = int'(ins[11:7]);
            if (n == 0 && (k == 2'b01 || k == 2'b10)) n = 32;
        end
        case (k)
            2'b00: for (int i = 0; i < n; i++) begin c = v[31]; v = v << 1; end
            2'b01: for (int i = 0; i < n; i++) begin c = v[0]; v = v >> 1; end
            2'b10: for (int i = 0; i < n; i++) begin c = v[0]; v = {v[31], v[31:1]}; end
            default: begin
                if (!regf && n == 0) begin
                    b0 = v[0];
                    v  = {cin, v[31:1]};
                    c  = b0;
                end else if (n != 0) begin
                    if (n % 32 == 0) c = v[31];
                    for (int i = 0; i < n % 32; i++) begin c = v[0]; v = {v[0], v[31:1]}; end
                end
            end
        endcase
        return {regf, c, v};
    endfunction

    // Builds an instruction word; the upper bits are arbitrary filler
    function automatic logic [31:0] mk(bit regf, logic [1:0] k, logic [4:0] imm,
                                       logic [3:0] rs_i, logic [3:0] rm_i);
        if (regf) return {20'hE1A3C, rs_i, 1'b0, k, 1'b1, rm_i};
        return {20'hE1A3C, imm, k, 1'b0, rm_i};
    endfunction

    // Driver: apply one stimulus at the falling edge and queue its expectation
    task automatic send(logic [31:0] ins, logic [31:0] rm, logic [31:0] rs,
                        logic cin, string tag);
        @(negedge clk);
        insn     = ins;
        rm_val   = rm;
        rs_val   = rs;
        carry_in = cin;
        exp_q.push_back(ref_model(ins, rm, rs, cin));
        tag_q.push_back(tag);
    endtask

    // Monitor: the item queued before this edge is captured here (R12 latency)
    initial begin
        forever begin
            @(posedge clk);
            if (exp_q.size() > 0) begin
                logic [33:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                #1;
                checks++;
                if ({carry_out, opnd_out} != e[32:0]) begin
                    errors++;
                    $display("FAIL %s insn=%h rm=%h rs=%h: got res=%h c=%b, expected res=%h c=%b",
                             t, insn, rm_val, rs_val, opnd_out, carry_out, e[31:0], e[32]);
                end
                checks++;
                if (extra_cycle != e[33]) begin
                    errors++;
                    $display("FAIL R11 extra_cycle: got %b, expected %b", extra_cycle, e[33]);
                end
            end
        end
    end

    function automatic string reg_tag(int k, logic [7:0] amt);
        if (amt == 8'd0) return "R6";
        if (k == 2) return "R8";
        if (k == 3) return "R9";
        return "R7";
    endfunction

    function automatic string imm_tag(int k, int amt);
        if (amt != 0) return "R2";
        if (k == 0) return "R3";
        if (k == 3) return "R5";
        return "R4";
    endfunction

    initial begin
        logic [31:0] vals[3];
        logic [31:0] ramts[8];
        int          imms[4];
        vals[0]  = 32'h8000_0001;
        vals[1]  = 32'h7FFF_FFFE;
        vals[2]  = 32'hA5C3_3C5A;
        ramts[0] = 32'd0;   ramts[1] = 32'd1;  ramts[2] = 32'd31;  ramts[3] = 32'd32;
        ramts[4] = 32'd33;  ramts[5] = 32'd255; ramts[6] = 32'd64; ramts[7] = 32'hFFFF_0105;
        imms[0] = 0; imms[1] = 1; imms[2] = 15; imms[3] = 31;

        // R12: outputs clear under synchronous reset despite active inputs
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (opnd_out !== 32'd0 || carry_out !== 1'b0 || extra_cycle !== 1'b0) begin
            errors++;
            $display("FAIL R12 reset: got res=%h c=%b x=%b, expected 0 0 0",
                     opnd_out, carry_out, extra_cycle);
        end
        rst_n = 1'b1;

        // Register form: every kind over the corner amounts (R6..R9)
        for (int k = 0; k < 4; k++)
            for (int a = 0; a < 8; a++)
                for (int v = 0; v < 3; v++)
                    send(mk(1'b1, 2'(k), 5'd0, 4'd2, 4'd1), vals[v], ramts[a],
                         1'((a + v) & 1), reg_tag(k, ramts[a][7:0]));

        // Immediate form: every kind with zero and nonzero amounts (R2..R5)
        for (int k = 0; k < 4; k++)
            for (int a = 0; a < 4; a++)
                for (int v = 0; v < 3; v++)
                    send(mk(1'b0, 2'(k), 5'(imms[a]), 4'd0, 4'd1), vals[v], 32'hFFFF_FFFF,
                         1'((a + v + 1) & 1), imm_tag(k, imms[a]));

        // R1: bit 4 alone switches the amount source (imm 2 vs Rs = 5)
        send(32'hE1A0_1102, 32'h0000_00F0, 32'd5, 1'b0, "R1");
        send(32'hE1A0_1112, 32'h0000_00F0, 32'd5, 1'b0, "R1");
        // R1: kind field selects the shift
        send(32'hE1A0_1142, 32'h8000_00F0, 32'd5, 1'b0, "R1");

        // R10: register 15 offsets in register form
        send(mk(1'b1, 2'b00, 5'd0, 4'hF, 4'd1), 32'h1234_5679, 32'd28, 1'b0, "R10");
        send(mk(1'b1, 2'b01, 5'd0, 4'hF, 4'd1), 32'h1234_5679, 32'hFFFF_FFFC, 1'b0, "R10");
        send(mk(1'b1, 2'b00, 5'd0, 4'd2, 4'hF), 32'h0000_1000, 32'd4, 1'b1, "R10");
        send(mk(1'b1, 2'b11, 5'd0, 4'hF, 4'hF), 32'hFFFF_FFFE, 32'd0, 1'b0, "R10");
        // R10: no offset in immediate form even with both fields at 15
        send({20'hE1A3C, 4'hF, 1'b1, 2'b00, 1'b0, 4'hF}, 32'h0000_0003, 32'd0, 1'b0, "R10");
        send({20'hE1A3C, 5'd0, 2'b00, 1'b0, 4'hF}, 32'h0000_0010, 32'd0, 1'b1, "R10");

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(WD_CYCLES * 5.0);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule